// File: doc/BRIEF.md
# Dual Fractional-Rate Interval Timers

This block holds two 8-bit up-counting interval timers that share one interrupt flag. Each timer is paced by the audio sample tick. A rational phase accumulator lets a timer advance on only a fraction of the ticks. Timer A adds 36/143 of a count per tick and timer B adds 9/143, so timer B runs four times slower than timer A.

When a counter rolls past its top value, it reloads from its preset. If the timer is not masked, the wrap also raises that timer's overflow flag and the shared interrupt flag. A host programs the block with single-byte writes to three targets: the preset of timer A, the preset of timer B and a control byte. The block shows its live state on plain outputs.

Writes have no handshake and are always taken in the cycle they are presented. There is no data stream, so there is no back-pressure.

Top module: `dual_interval_timer`

## Requirements
- R1: Each enabled tick adds 36 to timer A's accumulator. When the sum is strictly greater than 143, 143 is subtracted and the counter goes up by one in that same cycle. Starting from a cleared accumulator, the first increment comes on the 4th enabled tick.
- R2: Timer B does the same with a step of 9, so from a cleared accumulator its first increment comes on the 16th enabled tick.
- R3: A timer's accumulator and counter hold their values in any cycle where tick_i is low or that timer's enable is clear.
- R4: A control write (wr_sel_i = 2) with bit 7 clear loads the enables from bit 0 (timer A) and bit 1 (timer B). Bits 2 to 4 have no effect. New enables and masks apply from the following cycle.
- R5: When an increment would take a counter past 255, the counter loads its preset in that same step instead of showing zero.
- R6: A wrap on a timer whose mask is clear sets that timer's overflow flag and irq_o. A wrap on a masked timer leaves both flags unchanged.
- R7: The mask bits are crossed. Control bit 5 masks timer B (tmr_mask_o[1]) and control bit 6 masks timer A (tmr_mask_o[0]).
- R8: A control write with bit 7 set clears irq_o and both overflow flags. The rest of that byte is ignored, so the enables and masks keep their values.
- R9: A write with wr_sel_i = 0 (timer A) or 1 (timer B) stores the byte as the preset and loads it into the live counter on the next edge. In that cycle the load overrides any increment, and no wrap occurs.
- R10: cnt_a_o and cnt_b_o always show the live counters, not the presets.
- R11: A synchronous active-high reset clears the counters, presets, accumulators, enables, masks, overflow flags and irq_o.
- R12: If a clear command and an unmasked wrap happen in the same cycle, the wrap wins and its flags end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle sample tick |
| wr_en_i | input | 1 | Byte write strobe |
| wr_sel_i | input | 2 | Write target: 0 preset A, 1 preset B, 2 control, 3 none |
| wr_data_i | input | 8 | Write byte |
| cnt_a_o | output | 8 | Live counter of timer A |
| cnt_b_o | output | 8 | Live counter of timer B |
| tmr_en_o | output | 2 | Enables, bit 0 timer A, bit 1 timer B |
| tmr_mask_o | output | 2 | Masks, bit 0 timer A, bit 1 timer B |
| ovf_o | output | 2 | Overflow flags, bit 0 timer A, bit 1 timer B |
| irq_o | output | 1 | Shared interrupt flag |

## Verification
The accumulators are not visible at the ports, so a wrong accumulator value shows up only as an increment that lands on the wrong tick. For timer A this is seen within four enabled ticks; for timer B it can take up to sixteen. A wrong counter or preset value is visible on the next edge at cnt_a_o or cnt_b_o, but a wrong preset only shows after the next wrap. A swapped mask or a lost flag update is visible only in the cycle after a wrap, so the stimulus drives both timers through several wraps with each mask setting.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int CNT_W      = 8;
  localparam int CTL_EN_A   = 0;
  localparam int CTL_EN_B   = 1;
  localparam int CTL_MASK_B = 5;
  localparam int CTL_MASK_A = 6;
  localparam int CTL_CLR    = 7;

  typedef enum logic [1:0] {
    SEL_PRE_A = 2'd0,
    SEL_PRE_B = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/dit_phase_acc.sv
module dit_phase_acc #(
  parameter int STEP = 36,
  parameter int MOD  = 143
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  output logic inc_o
);
  localparam int ACC_W = $clog2(MOD + STEP + 1);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic             over;

  assign sum   = acc_q + ACC_W'(STEP);
  assign over  = sum > ACC_W'(MOD);
  assign inc_o = adv_i && over;

  always_ff @(posedge clk) begin
    if (rst)        acc_q <= '0;
    else if (adv_i) acc_q <= over ? (sum - ACC_W'(MOD)) : sum;
  end

  AST_ACC_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    acc_q <= ACC_W'(MOD)); // R1
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(acc_q)); // R3
endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] preset_q;

  assign wrap_o = step_i && !ld_i && (cnt_q == '1);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      preset_q <= '0;
    end else if (ld_i) begin
      cnt_q    <= ld_val_i;
      preset_q <= ld_val_i;
    end else if (step_i) begin
      cnt_q <= (cnt_q == '1) ? preset_q : cnt_q + 1'b1;
    end
  end

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == $past(preset_q))); // R5
  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> (cnt_q == $past(ld_val_i))); // R9
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ld_i && !step_i) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/dit_ctrl.sv
module dit_ctrl
  import dit_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr_i,
  input  logic [7:0] ctl_data_i,
  input  logic [1:0] wrap_i,
  output logic [1:0] en_o,
  output logic [1:0] mask_o,
  output logic [1:0] ovf_o,
  output logic       irq_o
);
  logic       clr_cmd;
  logic       cfg_cmd;
  logic [1:0] hit;

  assign clr_cmd = ctl_wr_i && ctl_data_i[CTL_CLR];
  assign cfg_cmd = ctl_wr_i && !ctl_data_i[CTL_CLR];
  assign hit     = wrap_i & ~mask_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= '0;
      mask_o <= '0;
    end else if (cfg_cmd) begin
      en_o   <= {ctl_data_i[CTL_EN_B], ctl_data_i[CTL_EN_A]};
      mask_o <= {ctl_data_i[CTL_MASK_B], ctl_data_i[CTL_MASK_A]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_o <= '0;
      irq_o <= 1'b0;
    end else begin
      ovf_o <= (clr_cmd ? 2'b00 : ovf_o) | hit;
      irq_o <= (clr_cmd ? 1'b0 : irq_o) | (|hit);
    end
  end

  AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (rst)
    (clr_cmd && !(|hit)) |=> (!irq_o && ovf_o == 2'b00)); // R8
  AST_CLEAR_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
    clr_cmd |=> ($stable(en_o) && $stable(mask_o))); // R8

  for (genvar g = 0; g < 2; g++) begin : g_flag
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
      (wrap_i[g] && mask_o[g] && !clr_cmd) |=> $stable(ovf_o[g])); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      (wrap_i[g] && !mask_o[g]) |=> (ovf_o[g] && irq_o)); // R12
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int STEP_A = 36,
  parameter int STEP_B = 9,
  parameter int MOD    = 143
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [7:0]       wr_data_i,
  output logic [CNT_W-1:0] cnt_a_o,
  output logic [CNT_W-1:0] cnt_b_o,
  output logic [1:0]       tmr_en_o,
  output logic [1:0]       tmr_mask_o,
  output logic [1:0]       ovf_o,
  output logic             irq_o
);
  localparam int NUM_TMR = 2;

  wr_sel_e          sel;
  logic [NUM_TMR-1:0] inc;
  logic [NUM_TMR-1:0] wrap;
  logic [CNT_W-1:0] cnt [NUM_TMR];

  assign sel = wr_sel_e'(wr_sel_i);

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    localparam int STEP = (g == 0) ? STEP_A : STEP_B;

    dit_phase_acc #(.STEP(STEP), .MOD(MOD)) u_acc (
      .clk   (clk),
      .rst   (rst),
      .adv_i (tick_i && tmr_en_o[g]),
      .inc_o (inc[g])
    );

    dit_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .ld_i     (wr_en_i && (wr_sel_i == 2'(g))),
      .ld_val_i (wr_data_i[CNT_W-1:0]),
      .step_i   (inc[g]),
      .cnt_o    (cnt[g]),
      .wrap_o   (wrap[g])
    );
  end

  dit_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ctl_wr_i   (wr_en_i && (sel == SEL_CTRL)),
    .ctl_data_i (wr_data_i),
    .wrap_i     (wrap),
    .en_o       (tmr_en_o),
    .mask_o     (tmr_mask_o),
    .ovf_o      (ovf_o),
    .irq_o      (irq_o)
  );

  assign cnt_a_o = cnt[0];
  assign cnt_b_o = cnt[1];

  AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(wrap) != 2'b00)); // R6
endmodule

// File: tb/dual_interval_timer_tb_top.sv
`timescale 1ns/1ps
module dual_interval_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] sel = 2'd3;
  logic [7:0] data = 8'h00;
  logic [7:0] cnt_a, cnt_b;
  logic [1:0] en, mask, ovf;
  logic       irq;

  int errors = 0;
  int checks = 0;

  int         macc [2];
  logic [7:0] mcnt [2];
  logic [7:0] mpre [2];
  logic [1:0] men, mmask, movf;
  logic       mirq;

  always #2.5 clk = ~clk;

  dual_interval_timer dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .wr_en_i(wr), .wr_sel_i(sel),
    .wr_data_i(data), .cnt_a_o(cnt_a), .cnt_b_o(cnt_b), .tmr_en_o(en),
    .tmr_mask_o(mask), .ovf_o(ovf), .irq_o(irq)
  );

  // {tag[23:20], reps[19:12], tick[11], wr[10], sel[9:8], data[7:0]}
  localparam int NVEC = 14;
  localparam logic [23:0] VEC [NVEC] = '{
    {4'd9,  8'd1,  1'b0, 1'b1, 2'd0, 8'hFE},
    {4'd9,  8'd1,  1'b0, 1'b1, 2'd1, 8'hFF},
    {4'd4,  8'd1,  1'b0, 1'b1, 2'd2, 8'h03},
    {4'd1,  8'd8,  1'b1, 1'b0, 2'd3, 8'h00},
    {4'd2,  8'd40, 1'b1, 1'b0, 2'd3, 8'h00},
    {4'd8,  8'd1,  1'b0, 1'b1, 2'd2, 8'h80},
    {4'd7,  8'd1,  1'b0, 1'b1, 2'd2, 8'h23},
    {4'd6,  8'd60, 1'b1, 1'b0, 2'd3, 8'h00},
    {4'd4,  8'd1,  1'b0, 1'b1, 2'd2, 8'h1C},
    {4'd3,  8'd20, 1'b1, 1'b0, 2'd3, 8'h00},
    {4'd7,  8'd1,  1'b0, 1'b1, 2'd2, 8'h43},
    {4'd6,  8'd40, 1'b1, 1'b0, 2'd3, 8'h00},
    {4'd9,  8'd1,  1'b1, 1'b1, 2'd0, 8'h10},
    {4'd10, 8'd30, 1'b1, 1'b0, 2'd3, 8'h00}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      macc[i] = 0; mcnt[i] = 8'h00; mpre[i] = 8'h00;
    end
    men = 2'b00; mmask = 2'b00; movf = 2'b00; mirq = 1'b0;
  endtask

  task automatic model_step(input logic t, input logic w, input logic [1:0] s,
                            input logic [7:0] d);
    logic [1:0] wrapped;
    logic       inc;
    wrapped = 2'b00;
    for (int i = 0; i < 2; i++) begin
      inc = 1'b0;
      if (t && men[i]) begin
        macc[i] += (i == 0) ? 36 : 9;
        if (macc[i] > 143) begin
          macc[i] -= 143;
          inc = 1'b1;
        end
      end
      if (w && s == 2'(i)) begin
        mcnt[i] = d; mpre[i] = d;
      end else if (inc) begin
        if (mcnt[i] == 8'hFF) begin
          mcnt[i] = mpre[i];
          wrapped[i] = 1'b1;
        end else begin
          mcnt[i] = mcnt[i] + 8'd1;
        end
      end
    end
    if (w && s == 2'd2 && d[7]) begin
      mirq = 1'b0; movf = 2'b00;
    end
    for (int i = 0; i < 2; i++)
      if (wrapped[i] && !mmask[i]) begin
        movf[i] = 1'b1; mirq = 1'b1;
      end
    if (w && s == 2'd2 && !d[7]) begin
      men = d[1:0];
      mmask = {d[5], d[6]};
    end
  endtask

  task automatic compare_all(input string tag);
    checks++;
    if (cnt_a !== mcnt[0] || cnt_b !== mcnt[1] || en !== men ||
        mask !== mmask || ovf !== movf || irq !== mirq) begin
      errors++;
      $display("FAIL %s actual a=%h b=%h en=%b mask=%b ovf=%b irq=%b expected a=%h b=%h en=%b mask=%b ovf=%b irq=%b",
               tag, cnt_a, cnt_b, en, mask, ovf, irq,
               mcnt[0], mcnt[1], men, mmask, movf, mirq);
    end
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic t, input logic w, input logic [1:0] s,
                       input logic [7:0] d, input string tag);
    @(negedge clk);
    tick = t; wr = w; sel = s; data = d;
    model_step(t, w, s, d);
    @(posedge clk);
    #1;
    tick = 1'b0; wr = 1'b0; sel = 2'd3;
    compare_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    model_reset();
    @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, run did not complete");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    compare_all("R11");

    for (int v = 0; v < NVEC; v++)
      for (int r = 0; r < int'(VEC[v][19:12]); r++)
        cycle(VEC[v][11], VEC[v][10], VEC[v][9:8], VEC[v][7:0],
              tag_name(VEC[v][23:20]));

    // R11: reset clears everything
    do_reset();
    check_val("R11 cnt", {cnt_a, cnt_b}, 16'h0000);
    check_val("R11 flags", {en, mask, ovf, irq}, 7'b0);

    // R1: timer A first increment on the 4th enabled tick
    cycle(1'b0, 1'b1, 2'd2, 8'h01, "R4");
    for (int k = 0; k < 3; k++) cycle(1'b1, 1'b0, 2'd3, 8'h00, "R1");
    check_val("R1 before 4th tick", cnt_a, 8'h00);
    cycle(1'b1, 1'b0, 2'd3, 8'h00, "R1");
    check_val("R1 4th tick", cnt_a, 8'h01);

    // R2: timer B first increment on the 16th enabled tick
    do_reset();
    cycle(1'b0, 1'b1, 2'd2, 8'h02, "R4");
    for (int k = 0; k < 15; k++) cycle(1'b1, 1'b0, 2'd3, 8'h00, "R2");
    check_val("R2 before 16th tick", cnt_b, 8'h00);
    cycle(1'b1, 1'b0, 2'd3, 8'h00, "R2");
    check_val("R2 16th tick", cnt_b, 8'h01);

    // R3: no tick, no movement
    for (int k = 0; k < 5; k++) cycle(1'b0, 1'b0, 2'd3, 8'h00, "R3");
    check_val("R3 hold", cnt_b, 8'h01);

    // R12 / R8 / R5: wrap in same cycle as clear
    do_reset();
    cycle(1'b0, 1'b1, 2'd0, 8'hFF, "R9");
    check_val("R10 live counter", cnt_a, 8'hFF);
    cycle(1'b0, 1'b1, 2'd2, 8'h01, "R4");
    for (int k = 0; k < 3; k++) cycle(1'b1, 1'b0, 2'd3, 8'h00, "R1");
    cycle(1'b1, 1'b1, 2'd2, 8'h80, "R12");
    check_val("R12 flags set", {ovf, irq}, 3'b011);
    check_val("R8 enables kept", en, 2'b01);
    check_val("R5 reload", cnt_a, 8'hFF);

    // R7: crossed masks
    cycle(1'b0, 1'b1, 2'd2, 8'h20, "R7");
    check_val("R7 bit5 masks B", mask, 2'b10);
    cycle(1'b0, 1'b1, 2'd2, 8'h40, "R7");
    check_val("R7 bit6 masks A", mask, 2'b01);

    summary();
    $finish;
  end
endmodule